// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the slave-side protocol engine of a small serial EEPROM with an SPI port. While chip select is low it shifts in bytes from the serial data input. The first byte is an opcode. Read and write opcodes are followed by a two-byte address, and the engine then either streams array contents out on the serial data output or collects data bytes for a page write. The SPI pins are oversampled by the block clock and are assumed to be synchronized to it already. The bus runs in mode 0: input bits are taken on the rising clock edge and the output bit changes on the falling edge.

The data array is a parameterised register file inside the block. Writes are staged in a one-page buffer and are copied into the array during a timed internal write cycle. That cycle starts only when chip select rises cleanly on a byte boundary. The write-enable latch and the status byte belong to a neighbouring status block. This engine sends that block pulses to set or clear write enable, to announce a status read and to deliver a status write. It takes back the latch state and the status byte to shift out.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset `busy_o`, `so_oe_o`, `wen_set_o`, `wen_clr_o`, `stat_rd_o` and `stat_wr_o` are all low.
- R2: An opcode byte is recognised only when its upper nibble is zero. Bit 3 is don't-care. The low three bits select the command: 110 set-enable, 100 clear-enable, 101 status read, 001 status write, 011 read, 010 write. 000 and 111 are unknown opcodes. A complete set-enable byte gives one `wen_set_o` pulse and a clear-enable byte gives one `wen_clr_o` pulse. An unknown opcode, or a byte with a nonzero upper nibble, gives no pulse, and the rest of that frame is ignored.
- R3: After a status-read opcode the byte on `stat_rdata_i` is shifted out MSB first. It is sent again for every further byte while chip select stays low.
- R4: After a read opcode the next two bytes form a 16-bit address, sent MSB first. Only its low `ADDR_W` bits are used. The array byte at that address is sent MSB first, and each following byte comes from the next address.
- R5: A continued read that passes address 2^ADDR_W-1 carries on from address 0.
- R6: Write data bytes land at successive offsets within the 2^PAGE_W-byte page of the start address. The offset wraps inside the page, so a later byte overwrites an earlier one at the same offset. Bytes outside that page are untouched.
- R7: While `busy_o` is high only the status-read opcode is acted on. During that time a read opcode returns 0x00 bytes and a set-enable opcode gives no pulse.
- R8: A write or status-write opcode that arrives while `wen_i` is low is ignored for the rest of the frame. It starts no write cycle and gives no `stat_wr_o` pulse, and the next frame is decoded normally.
- R9: A committed write holds `busy_o` high for `WR_CYCLES` clocks. It ends with one `wen_clr_o` pulse, which returns the device to the write-disabled state.
- R10: A write commits only when chip select rises after at least one whole data byte and no extra bits. A rise at any other bit count aborts the write and leaves the array unchanged.
- R11: A status write captures exactly one data byte. `stat_wr_o` pulses with that byte on `stat_wdata_o` only when chip select then rises on the byte boundary.
- R12: `so_oe_o` is high exactly while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock, mode 0 |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data input |
| so_o | output | 1 | Serial data output |
| so_oe_o | output | 1 | Output enable for `so_o` |
| wen_i | input | 1 | Write-enable latch state from the status block |
| stat_rdata_i | input | 8 | Status byte to shift out on a status read |
| wen_set_o | output | 1 | Pulse: set the write-enable latch |
| wen_clr_o | output | 1 | Pulse: clear the write-enable latch |
| stat_rd_o | output | 1 | Pulse: status read opcode accepted |
| stat_wr_o | output | 1 | Pulse: status write committed |
| stat_wdata_o | output | 8 | Byte for the status write |
| busy_o | output | 1 | Internal write cycle running |

## Verification
The hardest state to reach is the window of the internal write cycle. Several complete frames must be fitted into it and then checked: a status read, a read that must come back as zeros, and a set-enable that must stay silent. The bench therefore runs a long write-cycle parameter and issues these frames straight after a one-byte write commits. Chip-select rises at off-boundary bit counts are made with a partial-byte task. The page-wrap case writes 34 bytes from offset 30, and the bench then reads the neighbouring pages back across the whole array.

// File: rtl/see_pkg.sv
package see_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'b000,
        OP_WRSR  = 3'b001,
        OP_WRITE = 3'b010,
        OP_READ  = 3'b011,
        OP_WRDI  = 3'b100,
        OP_RDSR  = 3'b101,
        OP_WREN  = 3'b110,
        OP_RSVD  = 3'b111
    } opcode_e;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_AHI,
        ST_ALO,
        ST_RDAT,
        ST_WDAT,
        ST_SRD,
        ST_SWR,
        ST_DROP
    } cmd_state_e;

    // a byte is a known opcode when the upper nibble is clear and the code is assigned
    function automatic logic opc_known(input logic [7:0] b);
        return (b[7:4] == 4'b0000) && (b[2:0] != OP_NONE) && (b[2:0] != OP_RSVD);
    endfunction

endpackage

// File: rtl/see_spi_shift.sv
module see_spi_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       si_i,
    input  logic [7:0] tx_byte_i,
    output logic       byte_done_o,
    output logic [7:0] rx_byte_o,
    output logic       load_o,
    output logic       frame_end_o,
    output logic       aligned_o,
    output logic       so_o,
    output logic       so_oe_o
);
    logic       sck_q;
    logic       cs_q;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       done_q;
    logic       sck_rise;
    logic       sck_fall;

    assign sck_rise = !cs_n_i && sck_i && !sck_q;
    assign sck_fall = !cs_n_i && !sck_i && sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            done_q  <= 1'b0;
        end else begin
            sck_q  <= sck_i;
            cs_q   <= cs_n_i;
            done_q <= sck_rise && (bit_cnt == 3'd7);
            if (cs_n_i) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sh   <= {rx_sh[6:0], si_i};
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (sck_fall) begin
                    if (bit_cnt == 3'd0) begin
                        tx_sh <= tx_byte_i;
                    end else begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign byte_done_o = done_q;
    assign rx_byte_o   = rx_sh;
    assign load_o      = sck_fall && (bit_cnt == 3'd0);
    assign frame_end_o = cs_n_i && !cs_q;
    assign aligned_o   = (bit_cnt == 3'd0);
    assign so_o        = tx_sh[7];
    assign so_oe_o     = !cs_n_i;

endmodule

// File: rtl/see_cmd_ctrl.sv
module see_cmd_ctrl
    import see_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n_i,
    input  logic                     byte_done_i,
    input  logic [7:0]               rx_byte_i,
    input  logic                     load_i,
    input  logic                     frame_end_i,
    input  logic                     aligned_i,
    input  logic                     wen_i,
    input  logic                     busy_i,
    input  logic [7:0]               stat_rdata_i,
    input  logic [7:0]               rd_data_i,
    output logic [7:0]               tx_byte_o,
    output logic [ADDR_W-1:0]        rd_addr_o,
    output logic                     buf_we_o,
    output logic [PAGE_W-1:0]        buf_idx_o,
    output logic [7:0]               buf_data_o,
    output logic                     buf_clr_o,
    output logic                     commit_o,
    output logic [ADDR_W-PAGE_W-1:0] commit_page_o,
    output logic                     wen_set_o,
    output logic                     wen_clr_o,
    output logic                     stat_rd_o,
    output logic                     stat_wr_o,
    output logic [7:0]               stat_wdata_o
);
    cmd_state_e        state;
    logic              is_wr;
    logic [7:0]        addr_hi;
    logic [ADDR_W-1:0] addr;
    logic [PAGE_W-1:0] wptr;
    logic              have_data;
    logic [7:0]        stat_buf;
    logic              stat_pend;
    logic [15:0]       full_addr;
    opcode_e           opc;
    logic              opc_ok;
    logic              opc_act;

    assign full_addr = {addr_hi, rx_byte_i};
    assign opc       = opcode_e'(rx_byte_i[2:0]);
    assign opc_ok    = opc_known(rx_byte_i);
    assign opc_act   = byte_done_i && (state == ST_OPC) && opc_ok && (!busy_i || opc == OP_RDSR);

    always_comb begin
        wen_set_o     = opc_act && (opc == OP_WREN);
        wen_clr_o     = opc_act && (opc == OP_WRDI);
        stat_rd_o     = opc_act && (opc == OP_RDSR);
        buf_we_o      = byte_done_i && (state == ST_WDAT);
        buf_idx_o     = wptr;
        buf_data_o    = rx_byte_i;
        buf_clr_o     = byte_done_i && (state == ST_ALO) && is_wr;
        commit_o      = frame_end_i && aligned_i && (state == ST_WDAT) && have_data;
        commit_page_o = addr[ADDR_W-1:PAGE_W];
        stat_wr_o     = frame_end_i && aligned_i && (state == ST_SWR) && stat_pend;
        stat_wdata_o  = stat_buf;
        rd_addr_o     = addr;
        case (state)
            ST_RDAT: tx_byte_o = rd_data_i;
            ST_SRD:  tx_byte_o = stat_rdata_i;
            default: tx_byte_o = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OPC;
            is_wr     <= 1'b0;
            addr_hi   <= '0;
            addr      <= '0;
            wptr      <= '0;
            have_data <= 1'b0;
            stat_buf  <= '0;
            stat_pend <= 1'b0;
        end else if (cs_n_i) begin
            state     <= ST_OPC;
            is_wr     <= 1'b0;
            have_data <= 1'b0;
            stat_pend <= 1'b0;
        end else begin
            case (state)
                ST_OPC: if (byte_done_i) begin
                    if (!opc_act) begin
                        state <= ST_DROP;
                    end else begin
                        case (opc)
                            OP_READ:  begin state <= ST_AHI; is_wr <= 1'b0; end
                            OP_WRITE: begin
                                state <= wen_i ? ST_AHI : ST_DROP;
                                is_wr <= 1'b1;
                            end
                            OP_RDSR:  state <= ST_SRD;
                            OP_WRSR:  state <= wen_i ? ST_SWR : ST_DROP;
                            default:  state <= ST_DROP;
                        endcase
                    end
                end
                ST_AHI: if (byte_done_i) begin
                    addr_hi <= rx_byte_i;
                    state   <= ST_ALO;
                end
                ST_ALO: if (byte_done_i) begin
                    addr  <= full_addr[ADDR_W-1:0];
                    wptr  <= full_addr[PAGE_W-1:0];
                    state <= is_wr ? ST_WDAT : ST_RDAT;
                end
                ST_RDAT: if (load_i) begin
                    addr <= addr + 1'b1;
                end
                ST_WDAT: if (byte_done_i) begin
                    wptr      <= wptr + 1'b1;
                    have_data <= 1'b1;
                end
                ST_SWR: if (byte_done_i) begin
                    if (!stat_pend) begin
                        stat_buf  <= rx_byte_i;
                        stat_pend <= 1'b1;
                    end else begin
                        stat_pend <= 1'b0;
                        state     <= ST_DROP;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/see_page_array.sv
module see_page_array #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     buf_we_i,
    input  logic [PAGE_W-1:0]        buf_idx_i,
    input  logic [7:0]               buf_data_i,
    input  logic                     buf_clr_i,
    input  logic                     commit_i,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [7:0]               rd_data_o,
    output logic                     busy_o,
    output logic                     done_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [7:0]               mem  [DEPTH];
    logic [7:0]               pbuf [PAGE];
    logic [PAGE-1:0]          pvalid;
    logic                     busy_q;
    logic [CNT_W-1:0]         cnt;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0]        slot;
    logic                     in_copy;

    assign slot    = cnt[PAGE_W-1:0];
    assign in_copy = busy_q && (cnt < CNT_W'(PAGE));
    assign done_o  = busy_q && (cnt == CNT_W'(WR_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (in_copy && pvalid[slot]) begin
            mem[{page_q, slot}] <= pbuf[slot];
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we_i) begin
            pbuf[buf_idx_i] <= buf_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || buf_clr_i || done_o) begin
            pvalid <= '0;
        end else if (buf_we_i) begin
            pvalid[buf_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
        end else if (commit_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt    <= '0;
            page_q <= commit_page_i;
        end else if (busy_q) begin
            if (done_o) begin
                busy_q <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign busy_o    = busy_q;

endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       si_i,
    output logic       so_o,
    output logic       so_oe_o,
    input  logic       wen_i,
    input  logic [7:0] stat_rdata_i,
    output logic       wen_set_o,
    output logic       wen_clr_o,
    output logic       stat_rd_o,
    output logic       stat_wr_o,
    output logic [7:0] stat_wdata_o,
    output logic       busy_o
);
    logic                     byte_done;
    logic [7:0]               rx_byte;
    logic                     load;
    logic                     frame_end;
    logic                     aligned;
    logic [7:0]               tx_byte;
    logic [ADDR_W-1:0]        rd_addr;
    logic [7:0]               rd_data;
    logic                     buf_we;
    logic [PAGE_W-1:0]        buf_idx;
    logic [7:0]               buf_data;
    logic                     buf_clr;
    logic                     commit;
    logic [ADDR_W-PAGE_W-1:0] commit_page;
    logic                     cmd_wen_clr;
    logic                     wr_done;

    see_spi_shift shift_i (
        .clk         (clk),
        .rst         (rst),
        .sck_i       (sck_i),
        .cs_n_i      (cs_n_i),
        .si_i        (si_i),
        .tx_byte_i   (tx_byte),
        .byte_done_o (byte_done),
        .rx_byte_o   (rx_byte),
        .load_o      (load),
        .frame_end_o (frame_end),
        .aligned_o   (aligned),
        .so_o        (so_o),
        .so_oe_o     (so_oe_o)
    );

    see_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .cs_n_i        (cs_n_i),
        .byte_done_i   (byte_done),
        .rx_byte_i     (rx_byte),
        .load_i        (load),
        .frame_end_i   (frame_end),
        .aligned_i     (aligned),
        .wen_i         (wen_i),
        .busy_i        (busy_o),
        .stat_rdata_i  (stat_rdata_i),
        .rd_data_i     (rd_data),
        .tx_byte_o     (tx_byte),
        .rd_addr_o     (rd_addr),
        .buf_we_o      (buf_we),
        .buf_idx_o     (buf_idx),
        .buf_data_o    (buf_data),
        .buf_clr_o     (buf_clr),
        .commit_o      (commit),
        .commit_page_o (commit_page),
        .wen_set_o     (wen_set_o),
        .wen_clr_o     (cmd_wen_clr),
        .stat_rd_o     (stat_rd_o),
        .stat_wr_o     (stat_wr_o),
        .stat_wdata_o  (stat_wdata_o)
    );

    see_page_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) array_i (
        .clk           (clk),
        .rst           (rst),
        .buf_we_i      (buf_we),
        .buf_idx_i     (buf_idx),
        .buf_data_i    (buf_data),
        .buf_clr_i     (buf_clr),
        .commit_i      (commit),
        .commit_page_i (commit_page),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .busy_o        (busy_o),
        .done_o        (wr_done)
    );

    assign wen_clr_o = cmd_wen_clr || wr_done;

endmodule

// File: rtl/see_checker.sv
module see_checker (
    input logic clk,
    input logic rst,
    input logic cs_n_i,
    input logic wen_i,
    input logic busy_o,
    input logic wen_set_o,
    input logic wen_clr_o,
    input logic stat_wr_o
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) rst |=> !busy_o);

    // R7
    no_enable_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !wen_set_o);

    // R10
    commit_on_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(cs_n_i) && !$past(cs_n_i, 2)));

    // R8
    commit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(wen_i));

    // R9
    disable_at_cycle_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(wen_clr_o));

    // R11
    status_write_at_frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        stat_wr_o |-> cs_n_i);

endmodule

bind spi_eeprom_engine see_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .cs_n_i    (cs_n_i),
    .wen_i     (wen_i),
    .busy_o    (busy_o),
    .wen_set_o (wen_set_o),
    .wen_clr_o (wen_clr_o),
    .stat_wr_o (stat_wr_o)
);

// File: tb/spi_eeprom_engine_tb_top.sv
module spi_eeprom_engine_tb_top;
    localparam int AW    = 8;
    localparam int PW    = 5;
    localparam int WRC   = 600;
    localparam int HALF  = 4;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       so, so_oe;
    logic       wen_q = 1'b0;
    logic [7:0] snv = 8'h00;
    logic [7:0] stat_rdata;
    logic       wen_set, wen_clr, stat_rd, stat_wr, busy;
    logic [7:0] stat_wdata;

    int errors = 0;
    int checks = 0;
    int nset = 0;
    int nswr = 0;
    logic [7:0] expm [DEPTH];

    always #2 clk = ~clk;

    assign stat_rdata = busy ? 8'hFF : {snv[7:2], wen_q, 1'b0};

    spi_eeprom_engine #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WRC)) dut_i (
        .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .so_o(so), .so_oe_o(so_oe), .wen_i(wen_q), .stat_rdata_i(stat_rdata),
        .wen_set_o(wen_set), .wen_clr_o(wen_clr), .stat_rd_o(stat_rd),
        .stat_wr_o(stat_wr), .stat_wdata_o(stat_wdata), .busy_o(busy)
    );

    // model of the neighbouring status block
    always @(posedge clk) begin
        if (rst) begin
            wen_q <= 1'b0;
            snv   <= 8'h00;
        end else begin
            if (wen_set) begin wen_q <= 1'b1; nset <= nset + 1; end
            if (wen_clr) wen_q <= 1'b0;
            if (stat_wr) begin snv <= stat_wdata & 8'h8C; nswr <= nswr + 1; end
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cs_lo();
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] t, input int n, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            si = t[i];
            repeat (HALF) @(negedge clk);
            r[i] = so;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        xbits(t, 8, r);
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] r;
        cs_lo();
        xbyte(op, r);
        cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] r;
        cs_lo();
        xbyte(8'h05, r);
        xbyte(8'h00, v);
        cs_hi();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic read_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] r;
        cs_lo();
        xbyte(8'h03, r);
        xbyte(a[15:8], r);
        xbyte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            xbyte(8'hC3, r);
            chk(req, {8'h00, r}, {8'h00, expm[(int'(a) + i) % DEPTH]});
        end
        cs_hi();
    endtask

    logic [7:0] v, r;
    int base_set;

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 and R12 reset state
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 so_oe", {15'd0, so_oe}, 16'd0);
        chk("R1 pulses", {12'd0, wen_set, wen_clr, stat_rd, stat_wr}, 16'd0);

        // R12 output enable follows chip select
        cs_lo();
        chk("R12 so_oe low cs", {15'd0, so_oe}, 16'd1);
        cs_hi();
        chk("R12 so_oe high cs", {15'd0, so_oe}, 16'd0);

        // R2 nonzero upper nibble ignored
        one_op(8'h16);
        chk("R2 upper nibble", nset[15:0], 16'd0);
        one_op(8'h07);
        chk("R2 unknown code", nset[15:0], 16'd0);
        one_op(8'h0E);
        chk("R2 bit3 dont care", nset[15:0], 16'd1);
        rdsr(v);
        chk("R2 enable via status", {8'h00, v}, 16'h0002);
        one_op(8'h0C);
        rdsr(v);
        chk("R2 clear enable", {8'h00, v}, 16'h0000);

        // R8 status write without enable is ignored
        cs_lo(); xbyte(8'h01, r); xbyte(8'h8C, r); cs_hi();
        chk("R8 status write no enable", nswr[15:0], 16'd0);

        // R11 status write
        one_op(8'h06);
        cs_lo(); xbyte(8'h01, r); xbyte(8'h8C, r); cs_hi();
        chk("R11 status write count", nswr[15:0], 16'd1);
        // R3 status byte repeated
        cs_lo();
        xbyte(8'h05, r);
        xbyte(8'h00, v);
        chk("R3 status first", {8'h00, v}, 16'h008E);
        xbyte(8'h00, v);
        chk("R3 status repeat", {8'h00, v}, 16'h008E);
        cs_hi();
        // R11 off-boundary rise gives no status write
        cs_lo(); xbyte(8'h01, r); xbyte(8'h00, r); xbits(8'hFF, 3, r); cs_hi();
        chk("R11 partial rise", nswr[15:0], 16'd1);
        // R11 two data bytes give no status write
        cs_lo(); xbyte(8'h01, r); xbyte(8'h00, r); xbyte(8'h00, r); cs_hi();
        chk("R11 extra byte", nswr[15:0], 16'd1);
        cs_lo(); xbyte(8'h01, r); xbyte(8'h00, r); cs_hi();
        chk("R11 clear status", nswr[15:0], 16'd2);
        one_op(8'h04);

        // fill the whole array page by page, R9 after each
        for (int p = 0; p < DEPTH / 32; p++) begin
            one_op(8'h06);
            cs_lo();
            xbyte(8'h02, r);
            xbyte(8'h5A, r);
            xbyte(8'(p * 32), r);
            for (int j = 0; j < 32; j++) begin
                xbyte(pat(p * 32 + j), r);
                expm[p * 32 + j] = pat(p * 32 + j);
            end
            cs_hi();
            chk("R10 commit busy", {15'd0, busy}, 16'd1);
            repeat (WRC - 20) @(negedge clk);
            chk("R9 still busy", {15'd0, busy}, 16'd1);
            repeat (20) @(negedge clk);
            chk("R9 cycle ended", {15'd0, busy}, 16'd0);
            chk("R9 enable cleared", {15'd0, wen_q}, 16'd0);
        end

        // R4 and R5 continuous read across the top with upper bits set
        read_chk(16'h37F0, DEPTH + 4, "R4 R5 read wrap");

        // R6 page write wrap
        one_op(8'h06);
        cs_lo();
        xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h5E, r);
        for (int j = 0; j < 34; j++) begin
            xbyte(8'(8'hA0 + j), r);
            expm[8'h40 + ((30 + j) % 32)] = 8'(8'hA0 + j);
        end
        cs_hi();
        wait_idle();
        read_chk(16'h0020, 96, "R6 page wrap");

        // R7 busy window
        one_op(8'h06);
        cs_lo(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h80, r); xbyte(8'h55, r); cs_hi();
        expm[8'h80] = 8'h55;
        rdsr(v);
        chk("R7 status while busy", {8'h00, v}, 16'h00FF);
        cs_lo(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, v); cs_hi();
        chk("R7 read ignored", {8'h00, v}, 16'h0000);
        base_set = nset;
        one_op(8'h06);
        chk("R7 enable ignored", nset[15:0], base_set[15:0]);
        chk("R7 still busy", {15'd0, busy}, 16'd1);
        wait_idle();
        chk("R9 enable cleared after", {15'd0, wen_q}, 16'd0);
        read_chk(16'h0080, 1, "R7 write landed");

        // R8 write without enable
        cs_lo(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h90, r); xbyte(8'h11, r); cs_hi();
        chk("R8 no busy", {15'd0, busy}, 16'd0);
        read_chk(16'h0090, 1, "R8 array unchanged");
        rdsr(v);
        chk("R8 next frame decoded", {8'h00, v}, 16'h0000);

        // R10 abort on off-boundary rise
        one_op(8'h06);
        cs_lo(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'hA0, r); xbyte(8'h22, r); xbits(8'h33, 5, r); cs_hi();
        chk("R10 partial no busy", {15'd0, busy}, 16'd0);
        cs_lo(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'hA1, r); cs_hi();
        chk("R10 no data no busy", {15'd0, busy}, 16'd0);
        read_chk(16'h00A0, 2, "R10 array unchanged");
        one_op(8'h04);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule